// File: doc/BRIEF.md
# Storage Command Request Controller

This block sits between user logic and the back-end of a solid-state storage host controller. User logic presents one command at a time with a request strobe, a 3-bit command code, a start address and a transfer length. Address and length are both counted in 512-byte units. The controller accepts the request only while it is idle. It checks the parameters against the capacity and block size learned from the last Identify. It captures the parameters and hands the command to the back-end through a one-cycle start pulse. It then waits for the back-end's done pulse, guarded by a programmable timeout counted in clock cycles.

A request that fails the checks is refused without touching the back-end. The refusal and every other fault are recorded in a sticky error-type word with a summary flag. Both clear only on reset. After reset the controller reports busy until the back-end signals that initialization has finished. Capacity and the 4 KB block-size flag read zero until an Identify completes.

Top module: `cmdreq_ctrl`

## Requirements
- R1: After reset, busy is high, err is low, err_type, capacity and blk4k are zero and be_start is low; busy stays high until init_done is seen high, and falls in the cycle after that.
- R2: A request is taken only when req is high while busy is low. Busy is high in the cycle after the request is taken. A new request raised while busy is high starts nothing. For an accepted command, busy falls in the cycle after be_done is sampled high.
- R3: Command codes: 000 Identify, 001 Shutdown, 010 Write, 011 Read, 100 custom admin (SMART or secure erase), 110 Flush. Codes 101 and 111 are reserved and are refused. For any valid code, be_start pulses for one cycle in the cycle after acceptance, with be_cmd equal to the code. Address and length are checked only for Write (010) and Read (011).
- R4: A Write or Read with len equal to 0, or with addr+len greater than capacity, is refused; addr+len equal to capacity is accepted. With capacity still zero, every Write or Read is refused.
- R5: When blk4k is 1, a Write or Read whose addr[2:0] or len[2:0] is non-zero is refused; when blk4k is 0 those bits are not checked.
- R6: A refused request sets err_type bit 9 and never raises be_start. Busy is high for exactly one cycle, then the block is idle again.
- R7: be_cmd, be_addr and be_len hold the values captured at acceptance for the whole operation, whatever the request inputs do afterwards.
- R8: to_limit is captured at acceptance. When it is non-zero and be_done is not seen within to_limit cycles, counting from the cycle in which be_start is high, a timeout is raised at the end of the last of those cycles. The timeout sets err_type bit 4 for Write, Read or Flush and bit 2 for the other codes. Busy then stays high until reset.
- R9: A captured to_limit of zero disables the timeout. A be_done in the last allowed cycle completes the command normally, with no error.
- R10: When an Identify completes, be_blk_sel 0 loads capacity from be_cap and clears blk4k, and be_blk_sel 1 loads capacity and sets blk4k. Values 2 and 3 set err_type bit 6, leave capacity unchanged and keep busy high until reset.
- R11: err is high exactly when err_type is non-zero; err and every err_type bit stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| init_done | input | 1 | Back-end initialization finished |
| req | input | 1 | Command request strobe |
| cmd | input | 3 | Command code |
| addr | input | 48 | Start address, 512-byte units |
| len | input | 48 | Transfer length, 512-byte units |
| to_limit | input | 32 | Completion timeout in cycles, 0 disables |
| busy | output | 1 | Controller not idle |
| err | output | 1 | Sticky error summary |
| err_type | output | 32 | Sticky error bits |
| capacity | output | 48 | Device capacity, 512-byte units |
| blk4k | output | 1 | Device block size is 4 KB |
| be_start | output | 1 | One-cycle start pulse to back-end |
| be_cmd | output | 3 | Captured command code |
| be_addr | output | 48 | Captured start address |
| be_len | output | 48 | Captured length |
| be_done | input | 1 | Back-end completion pulse |
| be_cap | input | 48 | Capacity reported with Identify done |
| be_blk_sel | input | 2 | Block-size code reported with Identify done |

## Verification
Completion and timeout expiry can land in the same cycle. This happens when be_done arrives in the final cycle of the timeout window. The bench provokes it by programming a limit of four and returning done three cycles after the start cycle. It expects a clean completion with busy low and no timeout bit. A second run delays done by one more cycle; there it expects the I/O timeout bit and busy held high. A request held high while a command runs is a second overlap. The bench keeps a reserved code on the request lines during the run and expects neither a new start pulse nor a refusal bit.

// File: rtl/cmdreq_pkg.sv
package cmdreq_pkg;

  localparam logic [2:0] CMD_IDENT  = 3'b000;
  localparam logic [2:0] CMD_SHUTDN = 3'b001;
  localparam logic [2:0] CMD_WRITE  = 3'b010;
  localparam logic [2:0] CMD_READ   = 3'b011;
  localparam logic [2:0] CMD_ADMX   = 3'b100;
  localparam logic [2:0] CMD_RSV0   = 3'b101;
  localparam logic [2:0] CMD_FLUSH  = 3'b110;
  localparam logic [2:0] CMD_RSV1   = 3'b111;

  localparam int ERR_ADM_TO = 2;
  localparam int ERR_IO_TO  = 4;
  localparam int ERR_BLKSZ  = 6;
  localparam int ERR_REJECT = 9;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_REJ   = 3'd2,
    ST_RUN   = 3'd3,
    ST_FAULT = 3'd4
  } state_t;

  function automatic logic is_io_cmd(input logic [2:0] c);
    return (c == CMD_WRITE) || (c == CMD_READ) || (c == CMD_FLUSH);
  endfunction

endpackage

// File: rtl/cmdreq_check.sv
module cmdreq_check
  import cmdreq_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic [2:0]    cmd,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] cap,
  input  logic          blk4k,
  output logic          ok
);
  logic [AW:0] end_sum;
  logic        is_rw, is_rsv, range_ok, align_ok;

  always_comb begin
    end_sum  = {1'b0, addr} + {1'b0, len};
    is_rw    = (cmd == CMD_WRITE) || (cmd == CMD_READ);
    is_rsv   = (cmd == CMD_RSV0) || (cmd == CMD_RSV1);
    range_ok = (len != '0) && (end_sum <= {1'b0, cap});
    align_ok = !blk4k || ((addr[2:0] == 3'b000) && (len[2:0] == 3'b000));
    ok       = !is_rsv && (!is_rw || (range_ok && align_ok));
  end

endmodule

// File: rtl/cmdreq_timer.sv
module cmdreq_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [TW-1:0] limit_in,
  output logic          expired
);
  logic [TW-1:0] lim_q, lim_d;
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    lim_d = lim_q;
    cnt_d = cnt_q;
    if (load) begin
      lim_d = limit_in;
      cnt_d = '0;
    end else if (run) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (load || run) begin
      lim_q <= lim_d;
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && (lim_q != '0) && (cnt_q == lim_q - 1'b1);

  // R8: the controller must leave the run state before the window overruns
  p_cnt_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && lim_q != '0) |-> (cnt_q < lim_q));

endmodule

// File: rtl/cmdreq_ctrl.sv
module cmdreq_ctrl
  import cmdreq_pkg::*;
#(
  parameter int AW = 48,
  parameter int TW = 32,
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_done,
  input  logic          req,
  input  logic [2:0]    cmd,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] len,
  input  logic [TW-1:0] to_limit,
  output logic          busy,
  output logic          err,
  output logic [EW-1:0] err_type,
  output logic [AW-1:0] capacity,
  output logic          blk4k,
  output logic          be_start,
  output logic [2:0]    be_cmd,
  output logic [AW-1:0] be_addr,
  output logic [AW-1:0] be_len,
  input  logic          be_done,
  input  logic [AW-1:0] be_cap,
  input  logic [1:0]    be_blk_sel
);
  state_t        st_q, st_d;
  logic [2:0]    cmd_q, cmd_d;
  logic [AW-1:0] addr_q, addr_d, len_q, len_d, cap_q, cap_d;
  logic          b4k_q, b4k_d, start_q, start_d, err_q, err_d;
  logic [EW-1:0] et_q, et_d;
  logic          params_ok, t_load, t_run, t_exp;

  cmdreq_check #(.AW(AW)) u_check (
    .cmd(cmd), .addr(addr), .len(len), .cap(cap_q), .blk4k(b4k_q), .ok(params_ok)
  );

  assign t_load = (st_q == ST_IDLE) && req && params_ok;
  assign t_run  = (st_q == ST_RUN);

  cmdreq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .run(t_run),
    .limit_in(to_limit), .expired(t_exp)
  );

  always_comb begin
    st_d    = st_q;
    cmd_d   = cmd_q;
    addr_d  = addr_q;
    len_d   = len_q;
    cap_d   = cap_q;
    b4k_d   = b4k_q;
    err_d   = err_q;
    et_d    = et_q;
    start_d = 1'b0;
    unique case (st_q)
      ST_INIT: if (init_done) st_d = ST_IDLE;
      ST_IDLE: begin
        if (req) begin
          if (params_ok) begin
            st_d    = ST_RUN;
            cmd_d   = cmd;
            addr_d  = addr;
            len_d   = len;
            start_d = 1'b1;
          end else begin
            st_d             = ST_REJ;
            et_d[ERR_REJECT] = 1'b1;
            err_d            = 1'b1;
          end
        end
      end
      ST_REJ: st_d = ST_IDLE;
      ST_RUN: begin
        if (be_done) begin
          st_d = ST_IDLE;
          if (cmd_q == CMD_IDENT) begin
            if (be_blk_sel[1]) begin
              st_d            = ST_FAULT;
              et_d[ERR_BLKSZ] = 1'b1;
              err_d           = 1'b1;
            end else begin
              cap_d = be_cap;
              b4k_d = be_blk_sel[0];
            end
          end
        end else if (t_exp) begin
          st_d  = ST_FAULT;
          err_d = 1'b1;
          if (is_io_cmd(cmd_q)) et_d[ERR_IO_TO] = 1'b1;
          else                  et_d[ERR_ADM_TO] = 1'b1;
        end
      end
      ST_FAULT: st_d = ST_FAULT;
      default:  st_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_INIT;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      cap_q   <= '0;
      b4k_q   <= 1'b0;
      err_q   <= 1'b0;
      et_q    <= '0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      err_q   <= err_d;
      et_q    <= et_d;
      if (t_load) begin
        cmd_q  <= cmd_d;
        addr_q <= addr_d;
        len_q  <= len_d;
      end
      if (t_run && be_done) begin
        cap_q <= cap_d;
        b4k_q <= b4k_d;
      end
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign err      = err_q;
  assign err_type = et_q;
  assign capacity = cap_q;
  assign blk4k    = b4k_q;
  assign be_start = start_q;
  assign be_cmd   = cmd_q;
  assign be_addr  = addr_q;
  assign be_len   = len_q;

  p_start_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> ($past(req) && !$past(busy)));
  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> busy);
  p_no_rsv_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> (be_cmd != CMD_RSV0 && be_cmd != CMD_RSV1));
  p_reject_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(et_q[ERR_REJECT]) |-> (!be_start && busy));
  p_param_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(be_addr) && $stable(be_len) && $stable(be_cmd)));
  p_blksz_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(et_q[ERR_BLKSZ]) |-> (busy && $past(cmd_q) == CMD_IDENT));
  p_err_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err == (err_type != '0));
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) |-> err);

endmodule

// File: tb/cmdreq_ctrl_tb.sv
`timescale 1ns/1ps
module cmdreq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n, init_done, req, be_done;
  logic [2:0]  cmd;
  logic [47:0] addr, len, be_cap;
  logic [31:0] to_limit;
  logic [1:0]  be_blk_sel;
  logic        busy, err, blk4k, be_start;
  logic [31:0] err_type;
  logic [47:0] capacity, be_addr, be_len;
  logic [2:0]  be_cmd;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cmdreq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .req(req), .cmd(cmd),
    .addr(addr), .len(len), .to_limit(to_limit), .busy(busy), .err(err),
    .err_type(err_type), .capacity(capacity), .blk4k(blk4k), .be_start(be_start),
    .be_cmd(be_cmd), .be_addr(be_addr), .be_len(be_len), .be_done(be_done),
    .be_cap(be_cap), .be_blk_sel(be_blk_sel)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; be_done = 1'b0; init_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bring_up();
    init_done = 1'b1;
    @(negedge clk);
  endtask

  // Issues one request; accepted commands get done after dly cycles past the start cycle.
  task automatic run_cmd(input logic [2:0] c, input logic [47:0] a, input logic [47:0] l,
                         input bit acc, input int dly, input string tag);
    @(negedge clk);
    cmd = c; addr = a; len = l; req = 1'b1;
    @(negedge clk);
    chk({tag, " R2 busy after accept"}, busy, 1);
    if (acc) begin
      chk({tag, " R3 start"}, be_start, 1);
      chk({tag, " R3 be_cmd"}, be_cmd, c);
      chk({tag, " R7 be_addr"}, be_addr, a);
      chk({tag, " R7 be_len"}, be_len, l);
    end else begin
      chk({tag, " R6 no start"}, be_start, 0);
      chk({tag, " R6 reject bit"}, err_type[9], 1);
    end
    req = 1'b0; cmd = ~c; addr = ~a; len = ~l;
    if (!acc) begin
      @(negedge clk);
      chk({tag, " R6 idle after one cycle"}, busy, 0);
      return;
    end
    repeat (dly) @(negedge clk);
    chk({tag, " R7 addr held"}, be_addr, a);
    chk({tag, " R7 len held"}, be_len, l);
    be_done = 1'b1;
    @(negedge clk);
    be_done = 1'b0;
    chk({tag, " R2 busy falls after done"}, busy, 0);
  endtask

  task automatic identify(input logic [47:0] cap, input logic [1:0] sel);
    be_cap = cap; be_blk_sel = sel;
    run_cmd(3'b000, 48'd0, 48'd0, 1'b1, 2, "R10 identify");
    chk("R10 capacity", capacity, cap);
    chk("R10 blk4k", blk4k, sel[0]);
  endtask

  // {mode, cmd, addr, len, accept}
  localparam int NV = 17;
  localparam logic [100:0] VEC [NV] = '{
    {1'b0, 3'b010, 48'd0,    48'd8,  1'b1},  // R4 plain write
    {1'b0, 3'b011, 48'd992,  48'd8,  1'b1},  // R4 ends exactly at capacity
    {1'b0, 3'b011, 48'd993,  48'd8,  1'b0},  // R4 one past capacity
    {1'b0, 3'b010, 48'd5,    48'd3,  1'b1},  // R5 misalignment allowed in 512 mode
    {1'b0, 3'b010, 48'd0,    48'd0,  1'b0},  // R4 zero length
    {1'b0, 3'b101, 48'd0,    48'd8,  1'b0},  // R3 reserved
    {1'b0, 3'b111, 48'd0,    48'd8,  1'b0},  // R3 reserved
    {1'b0, 3'b001, 48'd0,    48'd0,  1'b1},  // R3 shutdown
    {1'b0, 3'b110, 48'd0,    48'd0,  1'b1},  // R3 flush
    {1'b0, 3'b100, 48'd7,    48'd0,  1'b1},  // R3 custom admin
    {1'b0, 3'b000, 48'd0,    48'd0,  1'b1},  // R3 identify
    {1'b1, 3'b010, 48'd8,    48'd16, 1'b1},  // R5 aligned
    {1'b1, 3'b010, 48'd9,    48'd16, 1'b0},  // R5 address misaligned
    {1'b1, 3'b011, 48'd8,    48'd12, 1'b0},  // R5 length misaligned
    {1'b1, 3'b011, 48'd1016, 48'd8,  1'b1},  // R4 exact end in 4K mode
    {1'b1, 3'b011, 48'd1016, 48'd16, 1'b0},  // R4 overflow in 4K mode
    {1'b1, 3'b110, 48'd3,    48'd0,  1'b1}   // R3 flush ignores addr/len
  };

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog all requirements actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit cur_mode;
    rst_n = 1'b1; init_done = 1'b0; req = 1'b0; be_done = 1'b0;
    cmd = '0; addr = '0; len = '0; to_limit = '0; be_cap = '0; be_blk_sel = '0;
    do_reset();
    // R1 reset state, busy held while init pending
    repeat (3) begin
      chk("R1 busy before init", busy, 1);
      @(negedge clk);
    end
    chk("R1 err", err, 0);
    chk("R1 err_type", err_type, 0);
    chk("R1 capacity", capacity, 0);
    chk("R1 blk4k", blk4k, 0);
    chk("R1 be_start", be_start, 0);
    bring_up();
    chk("R1 busy after init", busy, 0);

    // R2: request held during a running command starts nothing
    @(negedge clk);
    cmd = 3'b001; req = 1'b1;
    @(negedge clk);
    chk("R2 start", be_start, 1);
    cmd = 3'b101;
    repeat (3) begin
      @(negedge clk);
      chk("R2 no restart while busy", be_start, 0);
    end
    chk("R2 no reject while busy", err_type, 0);
    req = 1'b0; be_done = 1'b1;
    @(negedge clk);
    be_done = 1'b0;
    chk("R2 idle after done", busy, 0);

    // R4: capacity zero refuses every read; R11 flag follows word
    run_cmd(3'b011, 48'd0, 48'd1, 1'b0, 0, "R4 empty capacity");
    chk("R11 err set", err, 1);

    identify(48'd1000, 2'd0);
    cur_mode = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [100:0] v;
      v = VEC[i];
      if (v[100] != cur_mode) begin
        cur_mode = v[100];
        identify(cur_mode ? 48'd1024 : 48'd1000, {1'b0, cur_mode});
      end
      run_cmd(v[99:97], v[96:49], v[48:1], v[0], 2, cur_mode ? "R5 vec" : "R4 vec");
    end
    chk("R11 only reject bit", err_type, 32'h200);

    // R9: done in the last allowed cycle completes
    to_limit = 32'd4;
    run_cmd(3'b010, 48'd0, 48'd8, 1'b1, 3, "R9 edge done");
    chk("R9 no timeout", err_type, 32'h200);
    // R8: I/O timeout
    @(negedge clk);
    cmd = 3'b010; addr = 48'd0; len = 48'd8; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 not yet timed out", err_type[4], 0);
    @(negedge clk);
    chk("R8 io timeout bit", err_type[4], 1);
    chk("R8 admin bit clear", err_type[2], 0);
    repeat (5) @(negedge clk);
    chk("R8 busy held after timeout", busy, 1);

    do_reset();
    chk("R11 cleared by reset", err_type, 0);
    chk("R11 flag cleared", err, 0);
    bring_up();
    to_limit = 32'd0;
    // R9: zero limit never expires
    run_cmd(3'b001, 48'd0, 48'd0, 1'b1, 50, "R9 disabled");
    chk("R9 no error", err_type, 0);
    // R8: admin timeout
    to_limit = 32'd3;
    @(negedge clk);
    cmd = 3'b001; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 admin timeout bit", err_type, 32'h4);
    chk("R8 busy held", busy, 1);

    do_reset();
    bring_up();
    to_limit = 32'd0;
    // R10: unsupported block size
    be_cap = 48'd5000; be_blk_sel = 2'd2;
    @(negedge clk);
    cmd = 3'b000; req = 1'b1;
    @(negedge clk);
    req = 1'b0; be_done = 1'b1;
    @(negedge clk);
    be_done = 1'b0;
    chk("R10 blksz bit", err_type, 32'h40);
    chk("R10 capacity unchanged", capacity, 0);
    repeat (3) @(negedge clk);
    chk("R10 busy held", busy, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule